// File: doc/BRIEF.md
# Settled-Result Conversion Sequencer

This block decides when the decimation filter of a delta-sigma converter has produced a result that is fully settled, and raises a one-cycle data-ready strobe only for those results. A conversion starts on a rising level at the start pin or on a one-cycle start command. The block then waits through a lead time made of the start delay and a processing overhead. After that it counts filter output periods. The number of periods it needs depends on the filter selection (FIR, or sinc of order 1 to 4) and on whether chop mode is enabled.

In continuous mode, settled results follow at a steady rate after the first one. With chop off, that rate is one output period. With chop on, it is one filter-order's worth of periods. In single-shot mode the block returns to idle after the first settled result. The output period comes from a rate code. The slowest rate has `MAX_PERIOD` cycles, and each higher code halves it. FIR is legal only at the slowest rate codes. An FIR start at a faster code is refused and flagged.

Top module: `conv_settle_seq`

## Requirements
- R1: A start is accepted on a cycle where `start_pin` is high after being low in the previous cycle, or where `start_cmd` is high. Holding `start_pin` high does not start again.
- R2: The first `drdy` comes LEAD + L*P clock edges after the edge that accepts the start. LEAD = START_DLY + PROC_OVH. L is 1 for FIR (`fir_sel`=1) and `sinc_ord`+1 otherwise, so `sinc_ord` codes 0..3 mean sinc1..sinc4. P = MAX_PERIOD >> `rate_code`.
- R3: In continuous mode (`continuous`=1) with chop off, each later `drdy` comes P edges after the previous one.
- R4: With `chop_en`=1, the first `drdy` comes LEAD + 2*L*P edges after the start. Each later one in continuous mode comes L*P edges after the previous one.
- R5: In single-shot mode (`continuous`=0) exactly one `drdy` is produced. `busy` goes low on the same edge that raises `drdy`.
- R6: A start accepted while `busy` is high aborts the running conversion. It clears `settled_cnt` to 0 and runs the full sequence again with the new settings, and no `drdy` is given for the aborted run.
- R7: A start with `fir_sel`=1 and `rate_code` > FIR_MAX_CODE (3) is refused. It sets `cfg_err` and leaves the current state unchanged, whether idle or running. The next accepted start clears `cfg_err`.
- R8: `drdy` lasts one cycle and occurs only at settled points. `settled_cnt` rises by one with each `drdy`.
- R9: The filter, rate, chop and continuous settings are captured when a start is accepted. Changing them during a conversion has no effect on its timing.
- R10: After reset, `drdy`, `busy`, `settled_cnt` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pin | input | 1 | Level start request; its rising level starts a conversion |
| start_cmd | input | 1 | One-cycle start command strobe |
| fir_sel | input | 1 | 1 selects the FIR filter, 0 selects sinc |
| sinc_ord | input | 2 | Sinc order minus one (0..3 = sinc1..sinc4) |
| rate_code | input | RATE_W | Output-rate code; period = MAX_PERIOD >> code |
| chop_en | input | 1 | Chop mode enable |
| continuous | input | 1 | 1 = continuous conversions, 0 = single-shot |
| drdy | output | 1 | One-cycle strobe for a settled result |
| busy | output | 1 | High while a conversion sequence runs |
| settled_cnt | output | CNT_W | Settled results since the last accepted start |
| cfg_err | output | 1 | Set by a refused FIR start |

## Verification
Every result is due at a whole number of edges after the edge that accepts the start. The first result is due after LEAD plus the first-result periods times P. Each later result is due after the steady-state periods times P. Refusal, abort and the counter reset all show up one edge after the start is sampled. The bench model advances one countdown per posedge from the same inputs, and the outputs are compared on every falling edge. The directed latency checks count falling edges from the one that follows the capturing edge, so a measured gap equals the edge count in R2 to R4 with no off-by-one.

// File: rtl/conv_settle_pkg.sv
package conv_settle_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACC} phase_t;

  // Output period in clock cycles for a rate code.
  function automatic int period_cycles(input int max_p, input int code);
    return max_p >> code;
  endfunction

  // Effective filter order: FIR settles in one period.
  function automatic int filt_order(input logic fir, input int ord_code);
    return fir ? 1 : ord_code + 1;
  endfunction

  // Periods to the first settled result.
  function automatic int first_periods(input logic fir, input int ord_code, input logic chop);
    return chop ? 2 * filt_order(fir, ord_code) : filt_order(fir, ord_code);
  endfunction

  // Periods between later settled results in continuous mode.
  function automatic int next_periods(input logic fir, input int ord_code, input logic chop);
    return chop ? filt_order(fir, ord_code) : 1;
  endfunction

  function automatic logic fir_allowed(input logic fir, input int code, input int max_code);
    return !fir || (code <= max_code);
  endfunction

endpackage

// File: rtl/conv_settle_start.sv
module conv_settle_start (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pin,
  input  logic start_cmd,
  input  logic cfg_ok,
  output logic start_ok,
  output logic start_bad
);
  logic pin_q;
  logic req;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= start_pin;
  end

  assign req       = (start_pin & ~pin_q) | start_cmd;
  assign start_ok  = req & cfg_ok;
  assign start_bad = req & ~cfg_ok;
endmodule

// File: rtl/conv_settle_timer.sv
module conv_settle_timer #(
  parameter int LEAD  = 8,
  parameter int PER_W = 9,
  parameter int TGT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic [TGT_W-1:0]            first_tgt,
  input  logic [TGT_W-1:0]            next_tgt,
  input  logic [PER_W-1:0]            period,
  input  logic                        cont,
  output logic                        hit,
  output conv_settle_pkg::phase_t     phase
);
  import conv_settle_pkg::*;

  localparam int LEAD_W = $clog2(LEAD + 1);

  logic [LEAD_W-1:0] lead_cnt;
  logic [PER_W-1:0]  acc_cnt;
  logic [TGT_W-1:0]  per_n;
  logic [TGT_W-1:0]  tgt;
  logic              lead_end;
  logic              per_end;

  assign lead_end = (phase == PH_LEAD) && (lead_cnt == LEAD_W'(LEAD - 1));
  assign per_end  = (phase == PH_ACC) && (acc_cnt == period - PER_W'(1));
  assign hit      = per_end && ((per_n + TGT_W'(1)) == tgt) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      lead_cnt <= '0;
      acc_cnt  <= '0;
      per_n    <= '0;
      tgt      <= '0;
    end else if (restart) begin
      phase    <= PH_LEAD;
      lead_cnt <= '0;
      acc_cnt  <= '0;
      per_n    <= '0;
      tgt      <= first_tgt;
    end else begin
      case (phase)
        PH_LEAD: begin
          if (lead_end) begin
            phase    <= PH_ACC;
            lead_cnt <= '0;
          end else begin
            lead_cnt <= lead_cnt + LEAD_W'(1);
          end
        end
        PH_ACC: begin
          if (per_end) begin
            acc_cnt <= '0;
            if (hit) begin
              per_n <= '0;
              tgt   <= next_tgt;
              if (!cont) phase <= PH_IDLE;
            end else begin
              per_n <= per_n + TGT_W'(1);
            end
          end else begin
            acc_cnt <= acc_cnt + PER_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/conv_settle_seq.sv
module conv_settle_seq #(
  parameter int START_DLY    = 6,
  parameter int PROC_OVH     = 2,
  parameter int MAX_PERIOD   = 256,
  parameter int RATE_W       = 3,
  parameter int FIR_MAX_CODE = 3,
  parameter int CNT_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pin,
  input  logic              start_cmd,
  input  logic              fir_sel,
  input  logic [1:0]        sinc_ord,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              chop_en,
  input  logic              continuous,
  output logic              drdy,
  output logic              busy,
  output logic [CNT_W-1:0]  settled_cnt,
  output logic              cfg_err
);
  import conv_settle_pkg::*;

  localparam int LEAD  = START_DLY + PROC_OVH;
  localparam int PER_W = $clog2(MAX_PERIOD + 1);
  localparam int TGT_W = 4;

  logic              cfg_ok;
  logic              start_ok;
  logic              start_bad;
  logic              hit;
  phase_t            phase;
  logic [TGT_W-1:0]  first_tgt;
  logic [TGT_W-1:0]  next_live;
  logic [PER_W-1:0]  per_live;
  logic [PER_W-1:0]  per_q;
  logic [TGT_W-1:0]  next_q;
  logic              cont_q;

  assign cfg_ok    = fir_allowed(fir_sel, int'(rate_code), FIR_MAX_CODE);
  assign first_tgt = TGT_W'(first_periods(fir_sel, int'(sinc_ord), chop_en));
  assign next_live = TGT_W'(next_periods(fir_sel, int'(sinc_ord), chop_en));
  assign per_live  = PER_W'(period_cycles(MAX_PERIOD, int'(rate_code)));

  conv_settle_start u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_pin (start_pin),
    .start_cmd (start_cmd),
    .cfg_ok    (cfg_ok),
    .start_ok  (start_ok),
    .start_bad (start_bad)
  );

  // Settings held for the whole conversion.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      next_q <= '0;
      cont_q <= 1'b0;
    end else if (start_ok) begin
      per_q  <= per_live;
      next_q <= next_live;
      cont_q <= continuous;
    end
  end

  conv_settle_timer #(
    .LEAD  (LEAD),
    .PER_W (PER_W),
    .TGT_W (TGT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_ok),
    .first_tgt (first_tgt),
    .next_tgt  (next_q),
    .period    (per_q),
    .cont      (cont_q),
    .hit       (hit),
    .phase     (phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drdy        <= 1'b0;
      settled_cnt <= '0;
      cfg_err     <= 1'b0;
    end else begin
      drdy <= hit;
      if (start_ok)  settled_cnt <= '0;
      else if (hit)  settled_cnt <= settled_cnt + CNT_W'(1);
      if (start_bad)     cfg_err <= 1'b1;
      else if (start_ok) cfg_err <= 1'b0;
    end
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/conv_settle_chk.sv
module conv_settle_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drdy,
  input logic             busy,
  input logic [CNT_W-1:0] settled_cnt,
  input logic             cfg_err,
  input logic             start_ok,
  input logic             start_bad,
  input logic             cont_q,
  input logic             hit
);
  assert_hit_to_drdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> drdy);

  assert_single_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy && !cont_q) |-> !busy);

  assert_restart_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && !drdy && settled_cnt == '0));

  assert_reject_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bad && !busy) |=> (!busy && cfg_err));

  assert_drdy_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drdy |-> $past(busy));

  assert_drdy_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drdy |=> !drdy);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drdy |-> (settled_cnt == CNT_W'($past(settled_cnt) + 1'b1)));
endmodule

bind conv_settle_seq conv_settle_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drdy        (drdy),
  .busy        (busy),
  .settled_cnt (settled_cnt),
  .cfg_err     (cfg_err),
  .start_ok    (start_ok),
  .start_bad   (start_bad),
  .cont_q      (cont_q),
  .hit         (hit)
);

// File: tb/sim_conv_settle_seq.sv
module sim_conv_settle_seq;
  localparam int LEAD = 8;
  localparam int MAXP = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_pin = 1'b0;
  logic       start_cmd = 1'b0;
  logic       fir_sel = 1'b0;
  logic [1:0] sinc_ord = 2'd0;
  logic [2:0] rate_code = 3'd0;
  logic       chop_en = 1'b0;
  logic       continuous = 1'b0;
  logic       drdy;
  logic       busy;
  logic [7:0] settled_cnt;
  logic       cfg_err;

  int total = 0;
  int bad = 0;
  int wd = 0;

  always #2 clk = ~clk;

  conv_settle_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .start_cmd(start_cmd),
    .fir_sel(fir_sel), .sinc_ord(sinc_ord), .rate_code(rate_code),
    .chop_en(chop_en), .continuous(continuous), .drdy(drdy), .busy(busy),
    .settled_cnt(settled_cnt), .cfg_err(cfg_err)
  );

  // Behavioural reference: one countdown to the next settled result.
  bit m_pin_q, m_busy, m_drdy, m_err, m_cont, m_evt, m_bad;
  int m_rem, m_next, m_set, m_l, m_p;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pin_q = 0; m_busy = 0; m_drdy = 0; m_err = 0; m_cont = 0;
      m_rem = 0; m_next = 0; m_set = 0;
    end else begin
      m_evt = (start_pin && !m_pin_q) || start_cmd;
      m_pin_q = start_pin;
      m_bad = fir_sel && (rate_code > 3);
      m_drdy = 0;
      if (m_evt && m_bad) m_err = 1;
      if (m_evt && !m_bad) begin
        m_l = fir_sel ? 1 : int'(sinc_ord) + 1;
        m_p = MAXP >> rate_code;
        m_rem = LEAD + (chop_en ? 2 * m_l : m_l) * m_p;
        m_next = (chop_en ? m_l : 1) * m_p;
        m_cont = continuous;
        m_busy = 1; m_set = 0; m_err = 0;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_drdy = 1;
          m_set = (m_set + 1) % 256;
          if (m_cont) m_rem = m_next;
          else m_busy = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle compare against the model, away from the active edge.
  always @(negedge clk) begin
    check(drdy == m_drdy, "R2/R3/R4 drdy vs model", int'(drdy), int'(m_drdy));
    check(busy == m_busy, "R5 busy vs model", int'(busy), int'(m_busy));
    check(int'(settled_cnt) == m_set, "R8 settled_cnt vs model", int'(settled_cnt), m_set);
    check(cfg_err == m_err, "R7 cfg_err vs model", int'(cfg_err), int'(m_err));
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic kick();
    @(negedge clk) start_cmd = 1'b1;
    @(negedge clk) start_cmd = 1'b0;
  endtask

  task automatic cfg(input bit f, input int o, input int r, input bit c, input bit cn);
    fir_sel = f; sinc_ord = 2'(o); rate_code = 3'(r); chop_en = c; continuous = cn;
  endtask

  // Falling edges until the next drdy.
  task automatic meas(input int exp, input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!drdy && n < 5000);
    check(n == exp, tag, n, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R10 reset state
    check(!drdy && !busy && settled_cnt == 0 && !cfg_err, "R10 reset outputs",
          int'({drdy, busy, cfg_err}) + int'(settled_cnt), 0);
    rst_n = 1'b1;
    idle(2);

    // R2 FIR, slowest rate, single-shot
    cfg(1, 0, 0, 0, 0);
    kick();
    meas(LEAD + 256, "R2 FIR first latency");
    idle(2);
    check(!busy, "R5 idle after single result", int'(busy), 0);

    // R2 sinc3 at rate code 4
    cfg(0, 2, 4, 0, 0);
    kick();
    meas(LEAD + 3 * 16, "R2 sinc3 first latency");
    check(settled_cnt == 1, "R8 one settled result", int'(settled_cnt), 1);
    idle(3);

    // R1 + R3 start by pin, held high, sinc1 continuous
    cfg(0, 0, 5, 0, 1);
    @(negedge clk) start_pin = 1'b1;
    meas(LEAD + 8 + 1, "R1 pin start latency");
    for (int i = 0; i < 3; i++) meas(8, "R3 steady period (R1 held pin no restart)");
    check(settled_cnt == 4, "R8 count after four results", int'(settled_cnt), 4);

    // R4 chop sinc4 continuous, rate code 3
    start_pin = 1'b0;
    cfg(0, 3, 3, 1, 1);
    kick();
    meas(LEAD + 2 * 4 * 32, "R4 chop first latency");
    meas(4 * 32, "R4 chop steady period");

    // R6 abort mid-run, new single sinc2 at rate 5
    idle(20);
    cfg(0, 1, 5, 0, 0);
    kick();
    check(settled_cnt == 0, "R6 counter cleared on restart", int'(settled_cnt), 0);
    meas(LEAD + 2 * 8, "R6 restarted latency");
    check(settled_cnt == 1, "R6 count after restart", int'(settled_cnt), 1);
    idle(3);

    // R7 refused FIR start while idle
    cfg(1, 0, 6, 0, 0);
    kick();
    idle(10);
    check(!busy, "R7 refused start stays idle", int'(busy), 0);
    check(cfg_err, "R7 cfg_err set", int'(cfg_err), 1);

    // R7 refused start while running leaves the run alone
    cfg(0, 1, 5, 0, 1);
    kick();
    check(!cfg_err, "R7 accepted start clears cfg_err", int'(cfg_err), 0);
    idle(5);
    cfg(1, 0, 6, 0, 0);
    kick();
    check(busy && cfg_err, "R7 run continues with cfg_err", int'({busy, cfg_err}), 3);
    meas(LEAD + 2 * 8 - 7, "R7 first result on original schedule");
    meas(8, "R7 continuous period unchanged");

    // R9 settings changed after start are ignored
    cfg(0, 1, 5, 0, 0);
    kick();
    cfg(0, 3, 0, 1, 1);
    meas(LEAD + 2 * 8, "R9 latched latency");
    idle(3);
    check(!busy, "R9 latched single-shot", int'(busy), 0);

    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule